// File: doc/BRIEF.md
# Multiplexed Address/Data Parallel Port

This block runs an external parallel bus where sixteen shared pins carry first an address and then data. An internal requester presents one access at a time: a 24-bit byte address, write data, a read/write select and a width select for 8-bit or 16-bit transfers. The port drives the shared pins through a per-byte-lane output enable. It produces active-low read and write strobes and an address latch enable (ALE) that an external latch uses to hold the upper part of the address.

The port remembers which address bits the external latch currently holds. An access whose latched bits match the previous access skips the address phase entirely. In 16-bit mode the latched bits are address bits 15..0. In 8-bit mode they are address bits 23..8, and the low address byte travels beside the data byte during the strobe. ALE polarity is selectable. A flag-mode control releases the pins for general-purpose use and silences every bus control.

Every access follows the same order: an optional one-cycle address phase with ALE, a one-cycle setup, a strobe held for a programmed wait count plus one cycle, and a one-cycle hold. A one-cycle done pulse to the requester follows the hold.

Top module: `mux_parport`

## Requirements
- R1: In 8-bit mode (`cfg_wide`=0) an access issues an ALE pulse only when address bits 23..8 differ from those of the previous access. During that pulse `ad_out` carries address bits 23..8.
- R2: In 16-bit mode (`cfg_wide`=1) an access issues an ALE pulse only when address bits 15..0 differ from those of the previous access. During that pulse `ad_out` carries address bits 15..0.
- R3: The first access after reset, and the first access after any change of `cfg_wide`, always issues an ALE pulse.
- R4: ALE is active high when `cfg_ale_low`=0 and active low when `cfg_ale_low`=1. An address phase asserts it for exactly one cycle, with `ad_oe`=2'b11.
- R5: An access is accepted on a clock edge where `req_valid`=1 and `busy`=0. `req_done` is high for exactly one cycle, `a+W+4` cycles after the accepting edge, where `a` is 1 with an address phase and 0 without, and W is `cfg_wait` sampled at acceptance.
- R6: A read holds `rd_n` low for exactly W+1 consecutive cycles. `wr_n` stays high throughout the read.
- R7: A write holds `wr_n` low for exactly W+1 consecutive cycles, with `ad_oe`=2'b11. `rd_n` stays high. In 16-bit mode `ad_out` equals the 16-bit write data.
- R8: During a read strobe, 16-bit mode sets `ad_oe`=2'b00 and 8-bit mode sets `ad_oe`=2'b01. `ad_oe` bit 0 drives lane AD7..0 and bit 1 drives lane AD15..8. `req_rdata` is captured from `ad_in` in the last strobe cycle. In 16-bit mode it is all 16 bits. In 8-bit mode it is `ad_in[15:8]` zero-extended.
- R9: While `cfg_flag_mode`=1, requests are ignored (no `req_done`, `busy` low), `rd_n`=`wr_n`=1, ALE is inactive and `ad_oe`=2'b00. Leaving flag mode keeps the remembered latched address.
- R10: During and after reset, and whenever the port is idle outside flag mode, `ad_out`=0, `ad_oe`=2'b11, `rd_n`=`wr_n`=1 and ALE is inactive.
- R11: In 8-bit mode, during the strobe `ad_out[7:0]` carries address bits 7..0. For a write, `ad_out[15:8]` carries write data bits 7..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wide | input | 1 | 1: 16-bit transfers, 0: 8-bit transfers |
| cfg_ale_low | input | 1 | 1: ALE active low, 0: active high |
| cfg_flag_mode | input | 1 | 1: pins handed to flag use, port disabled |
| cfg_wait | input | 4 | Extra strobe cycles (strobe lasts cfg_wait+1) |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data (8-bit mode uses bits 7..0) |
| busy | output | 1 | Access in progress; requests not accepted |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Read data of the last read |
| ad_out | output | 16 | Value driven on the shared pins |
| ad_oe | output | 2 | Per-lane output enable (bit 0: AD7..0, bit 1: AD15..8) |
| ad_in | input | 16 | Value sensed on the shared pins |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ale | output | 1 | Address latch enable, polarity per cfg_ale_low |

## Verification
The pin controls are decoded directly from the sequencer state. ALE therefore appears in the first cycle after the accepting edge. The strobe begins one or two cycles after that edge, depending on whether an address phase was needed. `req_done` arrives `a+W+4` cycles after acceptance, and `req_rdata` is valid from that cycle onward. The bench changes inputs on falling edges and samples every cycle between acceptance and done at the falling edge. It counts ALE pulses, strobe cycles and elapsed cycles, so each result is compared in the cycle in which it is due.

// File: rtl/mpp_pkg.sv
// Package for the multiplexed parallel port: sequencer states and
// widths shared by all submodules. Assumes a 16-bit pin bus split into
// two byte lanes and a 24-bit byte address.
package mpp_pkg;
    localparam int ADDR_W = 24;
    localparam int PIN_W  = 16;
    localparam int LANE_W = PIN_W / 2;
    localparam int WAIT_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ADDR   = 3'd1,
        ST_SETUP  = 3'd2,
        ST_STROBE = 3'd3,
        ST_HOLD   = 3'd4
    } phase_t;

    // Address bits held by the external latch for the given width mode.
    function automatic logic [PIN_W-1:0] latch_key(input logic wide,
                                                   input logic [ADDR_W-1:0] addr);
        return wide ? addr[PIN_W-1:0] : addr[ADDR_W-1 -: PIN_W];
    endfunction
endpackage

// File: rtl/mpp_window.sv
// Latched-window tracker. Remembers the address bits last sent with ALE
// and reports whether a new access needs an address phase. The memory
// is invalidated by reset and by any change of the width mode. Assumes
// load is raised only on the edge that accepts an access.
module mpp_window
    import mpp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide,
    input  logic [ADDR_W-1:0] addr,
    input  logic              load,
    output logic              need_ale
);
    logic [PIN_W-1:0] held_key;
    logic             held_ok;
    logic             prev_wide;
    logic [PIN_W-1:0] new_key;

    // Key of the incoming address under the current mode.
    always_comb new_key = latch_key(wide, addr);

    // Address phase needed when nothing valid is held, mode moved, or key differs.
    always_comb need_ale = !held_ok || (prev_wide != wide) || (held_key != new_key);

    // Track mode and held key; a mode change drops the held key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_ok   <= 1'b0;
            held_key  <= '0;
            prev_wide <= 1'b0;
        end else begin
            prev_wide <= wide;
            if (load) begin
                held_ok  <= 1'b1;
                held_key <= new_key;
            end else if (prev_wide != wide) begin
                held_ok  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mpp_seq.sv
// Access sequencer. Accepts one request when idle and not in flag mode,
// latches it, and steps through address, setup, strobe and hold phases.
// Captures read data in the last strobe cycle and pulses done after hold.
// Flag mode returns it to idle at once. Assumes the requester holds
// its inputs stable only for the accepting edge.
module mpp_seq
    import mpp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_mode,
    input  logic              wide,
    input  logic [WAIT_W-1:0] wait_cfg,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [PIN_W-1:0]  req_wdata,
    input  logic              need_ale,
    input  logic [PIN_W-1:0]  ad_in,
    output logic              accept,
    output phase_t            phase,
    output logic              lat_write,
    output logic              lat_wide,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [PIN_W-1:0]  lat_wdata,
    output logic [PIN_W-1:0]  rdata,
    output logic              done
);
    logic [WAIT_W-1:0] lat_wait;
    logic [WAIT_W-1:0] cnt;

    // A request is taken only from idle outside flag mode.
    always_comb accept = req_valid && (phase == ST_IDLE) && !flag_mode;

    // Phase stepping, request latching, read capture and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= ST_IDLE;
            cnt       <= '0;
            lat_wait  <= '0;
            lat_write <= 1'b0;
            lat_wide  <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            rdata     <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (flag_mode) begin
                phase <= ST_IDLE;
            end else begin
                unique case (phase)
                    ST_IDLE: if (accept) begin
                        lat_write <= req_write;
                        lat_wide  <= wide;
                        lat_addr  <= req_addr;
                        lat_wdata <= req_wdata;
                        lat_wait  <= wait_cfg;
                        phase     <= need_ale ? ST_ADDR : ST_SETUP;
                    end
                    ST_ADDR:  phase <= ST_SETUP;
                    ST_SETUP: begin
                        cnt   <= lat_wait;
                        phase <= ST_STROBE;
                    end
                    ST_STROBE: begin
                        if (cnt == '0) begin
                            if (!lat_write)
                                rdata <= lat_wide ? ad_in
                                                  : {{LANE_W{1'b0}}, ad_in[PIN_W-1:LANE_W]};
                            phase <= ST_HOLD;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    ST_HOLD: begin
                        done  <= 1'b1;
                        phase <= ST_IDLE;
                    end
                    default: phase <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mpp_pins.sv
// Pin decoder. Turns the sequencer phase and latched request into the
// shared-bus value, per-lane enables, strobes and ALE. Flag mode forces
// every control inactive and releases both lanes. Purely combinational.
module mpp_pins
    import mpp_pkg::*;
(
    input  logic              flag_mode,
    input  logic              ale_low,
    input  phase_t            phase,
    input  logic              lat_write,
    input  logic              lat_wide,
    input  logic [ADDR_W-1:0] lat_addr,
    input  logic [PIN_W-1:0]  lat_wdata,
    output logic [PIN_W-1:0]  ad_out,
    output logic [1:0]        ad_oe,
    output logic              rd_n,
    output logic              wr_n,
    output logic              ale
);
    logic             ale_on;
    logic [PIN_W-1:0] data_word;
    logic [1:0]       data_oe;

    // Bus contents and lane enables for the setup, strobe and hold phases.
    always_comb begin
        if (lat_wide) begin
            data_word = lat_write ? lat_wdata : '0;
            data_oe   = lat_write ? 2'b11 : 2'b00;
        end else begin
            data_word = {(lat_write ? lat_wdata[LANE_W-1:0] : {LANE_W{1'b0}}),
                         lat_addr[LANE_W-1:0]};
            data_oe   = lat_write ? 2'b11 : 2'b01;
        end
    end

    // Per-phase pin drive, overridden by flag mode.
    always_comb begin
        ad_out = '0;
        ad_oe  = 2'b11;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        ale_on = 1'b0;
        if (flag_mode) begin
            ad_oe = 2'b00;
        end else begin
            unique case (phase)
                ST_ADDR: begin
                    ad_out = latch_key(lat_wide, lat_addr);
                    ale_on = 1'b1;
                end
                ST_SETUP, ST_HOLD: begin
                    ad_out = data_word;
                    ad_oe  = data_oe;
                end
                ST_STROBE: begin
                    ad_out = data_word;
                    ad_oe  = data_oe;
                    rd_n   = lat_write;
                    wr_n   = !lat_write;
                end
                default: ;
            endcase
        end
    end

    // Apply the selected ALE polarity.
    always_comb ale = ale_on ^ ale_low;
endmodule

// File: rtl/mux_parport.sv
// Multiplexed address/data parallel port, top level. Connects the
// latched-window tracker, the access sequencer and the pin decoder.
// Assumes one outstanding access at a time and an external address
// latch clocked by ALE.
module mux_parport
    import mpp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wide,
    input  logic              cfg_ale_low,
    input  logic              cfg_flag_mode,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [PIN_W-1:0]  req_wdata,
    output logic              busy,
    output logic              req_done,
    output logic [PIN_W-1:0]  req_rdata,
    output logic [PIN_W-1:0]  ad_out,
    output logic [1:0]        ad_oe,
    input  logic [PIN_W-1:0]  ad_in,
    output logic              rd_n,
    output logic              wr_n,
    output logic              ale
);
    logic              accept;
    logic              need_ale;
    phase_t            phase;
    logic              lat_write;
    logic              lat_wide;
    logic [ADDR_W-1:0] lat_addr;
    logic [PIN_W-1:0]  lat_wdata;

    mpp_window u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .wide     (cfg_wide),
        .addr     (req_addr),
        .load     (accept),
        .need_ale (need_ale)
    );

    mpp_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag_mode (cfg_flag_mode),
        .wide      (cfg_wide),
        .wait_cfg  (cfg_wait),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .need_ale  (need_ale),
        .ad_in     (ad_in),
        .accept    (accept),
        .phase     (phase),
        .lat_write (lat_write),
        .lat_wide  (lat_wide),
        .lat_addr  (lat_addr),
        .lat_wdata (lat_wdata),
        .rdata     (req_rdata),
        .done      (req_done)
    );

    mpp_pins u_pins (
        .flag_mode (cfg_flag_mode),
        .ale_low   (cfg_ale_low),
        .phase     (phase),
        .lat_write (lat_write),
        .lat_wide  (lat_wide),
        .lat_addr  (lat_addr),
        .lat_wdata (lat_wdata),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .ale       (ale)
    );

    // Busy whenever the sequencer is outside idle.
    always_comb busy = (phase != ST_IDLE);
endmodule

// File: rtl/mpp_checker.sv
// Protocol checker for mux_parport, attached through bind. Watches only
// top-level ports.
module mpp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_ale_low,
    input logic        cfg_flag_mode,
    input logic        busy,
    input logic        req_done,
    input logic [15:0] ad_out,
    input logic [1:0]  ad_oe,
    input logic        rd_n,
    input logic        wr_n,
    input logic        ale
);
    // R6/R7: the two strobes never overlap.
    a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R9: flag mode keeps every control inactive and both lanes released.
    a_r9_flag_silent: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_flag_mode |-> (rd_n && wr_n && (ale == cfg_ale_low) && ad_oe == 2'b00));

    // R4: ALE active for a single cycle unless the polarity itself moved.
    a_r4_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        (ale != cfg_ale_low) |=> ((ale == cfg_ale_low) || !$stable(cfg_ale_low)));

    // R5: done is a one-cycle pulse.
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);

    // R7: write strobe only with both lanes driven.
    a_r7_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (ad_oe == 2'b11));

    // R8: read strobe only with the upper lane released.
    a_r8_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe[1]);

    // R5: a strobe only occurs inside an accepted access.
    a_r5_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> busy);

    // R10: the cycle after a reset edge shows the idle pin state.
    a_r10_reset_idle: assert property (@(posedge clk)
        (!rst_n && !cfg_flag_mode) |=> (cfg_flag_mode ||
            (rd_n && wr_n && ad_out == 16'h0 && ad_oe == 2'b11 && ale == cfg_ale_low)));
endmodule

bind mux_parport mpp_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_ale_low   (cfg_ale_low),
    .cfg_flag_mode (cfg_flag_mode),
    .busy          (busy),
    .req_done      (req_done),
    .ad_out        (ad_out),
    .ad_oe         (ad_oe),
    .rd_n          (rd_n),
    .wr_n          (wr_n),
    .ale           (ale)
);

// File: tb/tb_mux_parport.sv
`timescale 1ns/100ps
module tb_mux_parport;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wide = 1'b1;
    logic        cfg_ale_low = 1'b0;
    logic        cfg_flag_mode = 1'b0;
    logic [3:0]  cfg_wait = 4'd0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, req_done, rd_n, wr_n, ale;
    logic [15:0] req_rdata, ad_out;
    logic [1:0]  ad_oe;
    logic [15:0] ad_in = '0;

    int errors = 0;
    int checks = 0;

    // bench model of the external latch contents
    logic        have_key = 1'b0;
    logic        model_wide = 1'b0;
    logic [15:0] model_key = '0;

    always #2.5 clk = ~clk;

    mux_parport dut (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_ale_low(cfg_ale_low),
        .cfg_flag_mode(cfg_flag_mode), .cfg_wait(cfg_wait), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .req_done(req_done), .req_rdata(req_rdata), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .rd_n(rd_n), .wr_n(wr_n), .ale(ale)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // vector: {write, wide, wait[3:0], addr[23:0], wdata[15:0], adin[15:0]}
    localparam int NV = 9;
    localparam logic [61:0] VEC [NV] = '{
        {1'b0, 1'b1, 4'd0, 24'h001234, 16'h0000, 16'hC3A5},  // first: ALE (R3)
        {1'b1, 1'b1, 4'd2, 24'h001234, 16'hBEEF, 16'h0000},  // same window (R2)
        {1'b0, 1'b1, 4'd1, 24'h001235, 16'h0000, 16'h5A5A},  // bit 0 moved (R2)
        {1'b1, 1'b1, 4'd0, 24'hAB1235, 16'h1357, 16'h0000},  // upper bits not latched
        {1'b1, 1'b0, 4'd0, 24'hAB1200, 16'h00E7, 16'h0000},  // width change (R3)
        {1'b0, 1'b0, 4'd3, 24'hAB12FF, 16'h0000, 16'h9D11},  // low byte only (R1)
        {1'b0, 1'b0, 4'd0, 24'hAB1300, 16'h0000, 16'h4422},  // bit 8 moved (R1)
        {1'b1, 1'b0, 4'd1, 24'h2B1300, 16'h0042, 16'h0000},  // bit 23 moved (R1)
        {1'b1, 1'b1, 4'd0, 24'h001235, 16'h0F0F, 16'h0000}   // back to wide (R3)
    };

    // One access: drive, watch every cycle to done, compare to the model.
    task automatic run_access(input bit wr, input bit wide, input logic [3:0] w,
                              input logic [23:0] a, input logic [15:0] d,
                              input logic [15:0] din);
        logic [15:0] key;
        bit   exp_ale;
        int   n, ale_cnt, rd_cnt, wr_cnt, bad_bus;
        key     = wide ? a[15:0] : a[23:8];
        exp_ale = !have_key || (model_wide != wide) || (model_key != key);
        ale_cnt = 0; rd_cnt = 0; wr_cnt = 0; bad_bus = 0;
        @(negedge clk);
        cfg_wide = wide; cfg_wait = w; req_write = wr; req_addr = a;
        req_wdata = d; ad_in = din; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (!req_done && n < 40) begin
            if (ale != cfg_ale_low) begin
                ale_cnt++;
                check(ad_out == key && ad_oe == 2'b11, wide ? "R2 ALE key" : "R1 ALE key",
                      {14'b0, ad_oe, ad_out}, {16'h3, key});
            end
            if (!rd_n) begin
                rd_cnt++;
                if (ad_oe != (wide ? 2'b00 : 2'b01)) bad_bus++;
                if (!wide && ad_out[7:0] != a[7:0]) bad_bus++;
            end
            if (!wr_n) begin
                wr_cnt++;
                if (ad_oe != 2'b11) bad_bus++;
                if (ad_out != (wide ? d : {d[7:0], a[7:0]})) bad_bus++;
            end
            @(negedge clk);
            n++;
        end
        check(ale_cnt == int'(exp_ale), "R1/R2/R3 ALE pulse count", ale_cnt, exp_ale);
        check(n == int'(exp_ale) + w + 4, "R5 done latency", n, int'(exp_ale) + w + 4);
        if (wr) begin
            check(wr_cnt == w + 1 && rd_cnt == 0, "R7 write strobe cycles",
                  {wr_cnt[15:0], rd_cnt[15:0]}, {16'(w + 1), 16'h0});
            check(bad_bus == 0, wide ? "R7 write bus" : "R11 byte lanes write", bad_bus, 0);
        end else begin
            check(rd_cnt == w + 1 && wr_cnt == 0, "R6 read strobe cycles",
                  {rd_cnt[15:0], wr_cnt[15:0]}, {16'(w + 1), 16'h0});
            check(bad_bus == 0, wide ? "R8 read enables" : "R11 byte lanes read", bad_bus, 0);
            check(req_rdata == (wide ? din : {8'h00, din[15:8]}), "R8 read data",
                  req_rdata, wide ? din : {8'h00, din[15:8]});
        end
        have_key   = 1'b1;
        model_wide = wide;
        model_key  = key;
        @(negedge clk);
        check(!req_done, "R5 done single cycle", req_done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: state during reset
        check(rd_n && wr_n && !ale && ad_out == 0 && ad_oe == 2'b11, "R10 during reset",
              {rd_n, wr_n, ale, ad_oe, ad_out}, {3'b110, 2'b11, 16'h0});
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(rd_n && wr_n && !ale && ad_out == 0 && ad_oe == 2'b11 && !busy,
              "R10 idle after reset", {busy, rd_n, wr_n, ale, ad_oe, ad_out},
              {4'b0110, 2'b11, 16'h0});

        for (int i = 0; i < NV; i++)
            run_access(VEC[i][61], VEC[i][60], VEC[i][59:56], VEC[i][55:32],
                       VEC[i][31:16], VEC[i][15:0]);

        // R9: flag mode ignores requests and silences the bus
        @(negedge clk);
        cfg_flag_mode = 1'b1;
        req_write = 1'b1; req_addr = 24'h777777; req_valid = 1'b1;
        begin
            int seen_done, bad;
            seen_done = 0; bad = 0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (req_done) seen_done++;
                if (!rd_n || !wr_n || ale || ad_oe != 2'b00 || busy) bad++;
            end
            check(seen_done == 0, "R9 request ignored", seen_done, 0);
            check(bad == 0, "R9 controls inactive", bad, 0);
        end
        req_valid = 1'b0;
        cfg_flag_mode = 1'b0;

        // R4: active-low ALE; idle level is high
        cfg_ale_low = 1'b1;
        @(negedge clk);
        check(ale == 1'b1 && ad_oe == 2'b11, "R4 ALE idle level active-low", {ad_oe, ale}, 3'b111);
        // R9: window survives flag mode, so no ALE here
        run_access(1'b0, 1'b1, 4'd0, 24'h991235, 16'h0, 16'h2468);
        // R4: new window pulses ALE low once
        run_access(1'b1, 1'b1, 4'd2, 24'h000001, 16'hA1B2, 16'h0);

        // R3: reset clears the remembered window
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        have_key = 1'b0;
        run_access(1'b0, 1'b1, 4'd0, 24'h000001, 16'h0, 16'h1111);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #20000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule